// File: doc/BRIEF.md
# Byte-Addressed GPIO Controller with Interrupts

This block is a small memory-mapped pin controller on a byte-wide register bus. A packed, read-only bank of level bytes comes first in the map. After it sits one control byte per pin. Each control byte holds a direction bit and the pin's current level. A write to a control byte handles the level bit in one of two ways, chosen by the direction written.

Outside logic reports pin levels through a single update port. When an update really changes a level on one of the first ten pins, the interrupt line for that pin follows the new level. A dedicated pulse input drives the edge pin high for one cycle and then low again, which gives a one-cycle interrupt pulse. Updates that reach a pin set as an output raise an error flag. Updates that change a pin with no interrupt line raise a separate status flag.

Top module: `gpio_byte_ctrl`

## Requirements
- R1: Address 0 to 7 read as level bytes: bit b of byte k is the level (control bit 1) of pin 8k+b, and is 0 for pins that do not exist. Address 8+p reads the control byte of pin p, for p from 0 to 35. Read data is registered and appears on rdata_o in the cycle after rd_en_i.
- R2: Addresses 44 and above read as zero, and writes to them change nothing.
- R3: Writes to addresses 0 to 7 are ignored.
- R4: In a control byte, bit 2 set means output. When written data has bit 2 set, bit 1 takes data bit 0. Otherwise bit 1 keeps its old value. All other bits take the written data.
- R5: An update on the port sets bit 1 of the target pin. If that pin is an output, out_err_o is high for the cycle after the update, and the update is still applied.
- R6: An update to the level a pin already holds changes no control byte, no interrupt line and no unimplemented flag.
- R7: irq_o[i] for pins 0 to 9 takes the new level in the cycle after an update that changes that pin's level. Bus writes never move an interrupt line.
- R8: After reset every control byte is 0x00 except pin 1, which is 0x02. irq_o is 0x002, and rdata_o and both flags are 0.
- R9: After the edge that samples pulse_i, pin 9's level and irq_o[9] are high. After the next edge they are low. The update port is not used during those two cycles.
- R10: An update that changes the level of a pin from 10 to 35 changes only its level bit. It raises unimpl_o for one cycle and leaves irq_o alone.
- R11: When a bus write and an update hit the same control byte in the same cycle, the control byte takes the bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| ext_vld_i | input | 1 | Pin level update valid |
| ext_pin_i | input | 6 | Pin index of the update |
| ext_lvl_i | input | 1 | New level of the update |
| pulse_i | input | 1 | Request for an edge pulse on pin 9 |
| irq_o | output | 10 | Interrupt lines of pins 0 to 9 |
| out_err_o | output | 1 | Update hit an output pin |
| unimpl_o | output | 1 | Level change on a pin without an interrupt line |

## Verification
Every result sits one register away from its stimulus. Read data, control bytes, interrupt lines and both flags all appear after the single clock edge that samples the strobe or update. The pulse is the exception: its high phase appears after that first edge and its low phase after the second. The bench drives inputs on the falling edge and samples on the next falling edge. It therefore looks at each result exactly one edge after it was caused. The pulse test samples on two falling edges in a row to see both phases.

// File: rtl/gpio_byte_ctrl.sv
module gpio_byte_ctrl #(
  parameter int NUM_PINS  = 36,
  parameter int LVL_BYTES = 8,
  parameter int NUM_IRQ   = 10,
  parameter int EDGE_PIN  = 9,
  parameter int BOOT_PIN  = 1,
  parameter int AW        = 6,
  parameter int PIN_W     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  output logic [7:0]         rdata_o,
  input  logic               ext_vld_i,
  input  logic [PIN_W-1:0]   ext_pin_i,
  input  logic               ext_lvl_i,
  input  logic               pulse_i,
  output logic [NUM_IRQ-1:0] irq_o,
  output logic               out_err_o,
  output logic               unimpl_o
);
  localparam int LVL_BITS = LVL_BYTES * 8;

  logic [NUM_PINS-1:0][7:0] ctl_q;
  logic [NUM_IRQ-1:0]       irq_q;
  logic [7:0]               rdata_q;
  logic                     pulse_hi_q, err_q, unimpl_q;
  logic [LVL_BITS-1:0]      lvl_vec;

  logic             upd_vld, upd_lvl, upd_hit, upd_chg;
  logic [PIN_W-1:0] upd_idx;
  logic [7:0]       upd_cur, rd_val;

  for (genvar g = 0; g < LVL_BITS; g++) begin : g_lvl
    if (g < NUM_PINS) begin : g_on
      assign lvl_vec[g] = ctl_q[g][1];
    end else begin : g_off
      assign lvl_vec[g] = 1'b0;
    end
  end

  always_comb begin
    if (pulse_i) begin
      upd_vld = 1'b1; upd_idx = PIN_W'(EDGE_PIN); upd_lvl = 1'b1;
    end else if (pulse_hi_q) begin
      upd_vld = 1'b1; upd_idx = PIN_W'(EDGE_PIN); upd_lvl = 1'b0;
    end else begin
      upd_vld = ext_vld_i; upd_idx = ext_pin_i; upd_lvl = ext_lvl_i;
    end
    upd_cur = 8'h00;
    for (int p = 0; p < NUM_PINS; p++)
      if (upd_idx == PIN_W'(p)) upd_cur = ctl_q[p];
  end

  assign upd_hit = upd_vld && (int'(upd_idx) < NUM_PINS);
  assign upd_chg = upd_hit && (upd_cur[1] != upd_lvl);

  always_comb begin
    rd_val = 8'h00;
    for (int b = 0; b < LVL_BYTES; b++)
      if (addr_i == AW'(b)) rd_val = lvl_vec[b*8 +: 8];
    for (int p = 0; p < NUM_PINS; p++)
      if (addr_i == AW'(LVL_BYTES + p)) rd_val = ctl_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PINS; p++)
        ctl_q[p] <= (p == BOOT_PIN) ? 8'h02 : 8'h00;
      irq_q      <= NUM_IRQ'(1) << BOOT_PIN;
      rdata_q    <= 8'h00;
      pulse_hi_q <= 1'b0;
      err_q      <= 1'b0;
      unimpl_q   <= 1'b0;
    end else begin
      pulse_hi_q <= pulse_i;
      err_q      <= upd_hit && upd_cur[2];
      unimpl_q   <= upd_chg && (int'(upd_idx) >= NUM_IRQ);
      for (int p = 0; p < NUM_PINS; p++)
        if (upd_chg && upd_idx == PIN_W'(p)) ctl_q[p][1] <= upd_lvl;
      for (int i = 0; i < NUM_IRQ; i++)
        if (upd_chg && upd_idx == PIN_W'(i)) irq_q[i] <= upd_lvl;
      for (int p = 0; p < NUM_PINS; p++)
        if (wr_en_i && addr_i == AW'(LVL_BYTES + p))
          ctl_q[p] <= {wdata_i[7:2], (wdata_i[2] ? wdata_i[0] : ctl_q[p][1]), wdata_i[0]};
      if (rd_en_i) rdata_q <= rd_val;
    end
  end

  assign rdata_o   = rdata_q;
  assign irq_o     = irq_q;
  assign out_err_o = err_q;
  assign unimpl_o  = unimpl_q;

  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i && int'(addr_i) >= LVL_BYTES + NUM_PINS |=> rdata_o == 8'h00); // R2
  AST_LVL_WRITE_RO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && int'(addr_i) < LVL_BYTES && !upd_vld |=> $stable(ctl_q)); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_chg |=> $stable(irq_o)); // R7
  AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_hi_q && !pulse_i |=> !irq_o[EDGE_PIN]); // R9
  AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_i |=> irq_o[EDGE_PIN]); // R9
  AST_UNIMPL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    unimpl_o |-> $stable(irq_o)); // R10
endmodule

// File: tb/gpio_byte_ctrl_tb_top.sv
module gpio_byte_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] rdata_o;
  logic       ext_vld_i = 1'b0;
  logic [5:0] ext_pin_i = '0;
  logic       ext_lvl_i = 1'b0;
  logic       pulse_i = 1'b0;
  logic [9:0] irq_o;
  logic       out_err_o, unimpl_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_byte_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
    .ext_vld_i(ext_vld_i), .ext_pin_i(ext_pin_i), .ext_lvl_i(ext_lvl_i),
    .pulse_i(pulse_i), .irq_o(irq_o), .out_err_o(out_err_o), .unimpl_o(unimpl_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic ext_upd(input logic [5:0] p, input logic l);
    ext_pin_i = p; ext_lvl_i = l; ext_vld_i = 1'b1;
    @(negedge clk); ext_vld_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R8 irq", irq_o, 10'h002);
    chk("R8 err", out_err_o, 0);
    chk("R8 unimpl", unimpl_o, 0);
    bus_rd(6'd9, d);  chk("R8 pin1 ctl", d, 8'h02);
    bus_rd(6'd8, d);  chk("R8 pin0 ctl", d, 8'h00);
    bus_rd(6'd0, d);  chk("R1 level byte0", d, 8'h02);
  endtask

  task automatic t_ext_input;
    logic [7:0] d;
    ext_upd(6'd3, 1'b1);
    chk("R7 irq3 high", irq_o, 10'h00A);
    chk("R5 no err input", out_err_o, 0);
    bus_rd(6'd11, d); chk("R5 pin3 ctl", d, 8'h02);
    bus_rd(6'd0, d);  chk("R1 level byte0", d, 8'h0A);
    ext_upd(6'd3, 1'b1);
    chk("R6 irq unchanged", irq_o, 10'h00A);
    bus_rd(6'd11, d); chk("R6 ctl unchanged", d, 8'h02);
    ext_upd(6'd3, 1'b0);
    chk("R7 irq3 low", irq_o, 10'h002);
  endtask

  task automatic t_ctl_write;
    logic [7:0] d;
    bus_wr(6'd13, 8'h05);
    bus_rd(6'd13, d); chk("R4 output write mirrors bit0", d, 8'h07);
    chk("R7 bus write no irq", irq_o, 10'h002);
    bus_wr(6'd13, 8'h04);
    bus_rd(6'd13, d); chk("R4 output write bit0 clear", d, 8'h04);
    ext_upd(6'd5, 1'b1);
    chk("R5 err on output pin", out_err_o, 1);
    bus_rd(6'd13, d); chk("R5 level still applied", d, 8'h06);
    chk("R5 err one cycle", out_err_o, 0);
    bus_wr(6'd9, 8'hF1);
    bus_rd(6'd9, d); chk("R4 input write keeps level", d, 8'hF3);
  endtask

  task automatic t_readonly;
    logic [7:0] d0, d1;
    bus_rd(6'd0, d0);
    bus_wr(6'd0, 8'hFF);
    bus_rd(6'd0, d1); chk("R3 level byte not written", d1, d0);
    bus_wr(6'd50, 8'hAA);
    bus_rd(6'd50, d1); chk("R2 unmapped read zero", d1, 8'h00);
    bus_rd(6'd44, d1); chk("R2 first unmapped zero", d1, 8'h00);
    bus_rd(6'd43, d1); chk("R2 last pin untouched", d1, 8'h00);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    logic [9:0] irq_before;
    irq_before = irq_o;
    ext_upd(6'd20, 1'b1);
    chk("R10 unimpl flag", unimpl_o, 1);
    chk("R10 irq untouched", irq_o, irq_before);
    bus_rd(6'd2, d); chk("R10 level byte2", d, 8'h10);
    chk("R10 flag one cycle", unimpl_o, 0);
    ext_upd(6'd20, 1'b1);
    chk("R6 no unimpl on same level", unimpl_o, 0);
  endtask

  task automatic t_pulse;
    logic [7:0] d;
    pulse_i = 1'b1;
    @(negedge clk); pulse_i = 1'b0;
    chk("R9 irq9 high", irq_o[9], 1);
    @(negedge clk);
    chk("R9 irq9 low", irq_o[9], 0);
    bus_rd(6'd1, d); chk("R9 pin9 level low", d, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] d;
    addr_i = 6'd10; wdata_i = 8'h00; wr_en_i = 1'b1;
    ext_pin_i = 6'd2; ext_lvl_i = 1'b1; ext_vld_i = 1'b1;
    @(negedge clk); wr_en_i = 1'b0; ext_vld_i = 1'b0;
    bus_rd(6'd10, d); chk("R11 bus write wins", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ext_input();
    t_ctl_write();
    t_readonly();
    t_unimpl();
    t_pulse();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule